// File: doc/BRIEF.md
# Execute-Stage Read-After-Write Interlock

This block is the stall controller for a five-stage, in-order, single-issue pipeline without operand forwarding. The stages are fetch, decode, execute, memory and writeback. The pipeline reports three things each cycle: the source and destination register numbers of the instruction in execute, the destination held in the memory stage, and the destination held in the writeback stage. From these the block decides whether the instruction in execute may run this cycle.

The dependence check is made in the execute stage. An instruction that reads a register still owed by an older, unfinished writer stays in execute. It runs only in the cycle after that writer's writeback cycle. While execute is held, fetch and decode are frozen as well, and the memory stage is handed an empty slot.

Each architectural register has one pending-write flag. A flag is raised when a writing instruction leaves execute. It is dropped when that writer finishes writeback, unless a younger writer of the same register is still on its way.

Because stall cycles in execute also delay the instructions behind, a stall can remove a dependence that would otherwise have cost further cycles later in the stream.

Top module: `raw_interlock`

## Requirements
- R1: With no pending dependences, every instruction advances one stage per cycle. Instruction k (counted from 1) executes in cycle k+2 and writes back in cycle k+4. When the execute slot is empty, no hold is raised.
- R2: An instruction whose source matches the destination of an older writer that has not completed writeback stays in execute. It executes in the cycle after that writer's writeback cycle. A consumer directly behind its producer occupies execute for three cycles.
- R3: The outputs `hold_fetch`, `hold_decode` and `hold_execute` are asserted together, in exactly the cycles in which the execute instruction is blocked. Fetch and decode repeat their stage for those cycles.
- R4: In every stalled cycle `mem_bubble` is asserted, so the memory stage receives an empty slot (destination 0). Each instruction reaches writeback exactly once.
- R5: A dependence on a writer that has already finished writeback causes no stall. A reader three instructions behind its producer does not stall. A reader two instructions behind stalls for one cycle.
- R6: Write-after-read and write-after-write orderings never stall.
- R7: Register 0 is never a hazard source. Destination 0 means "no write" and sets no pending flag.
- R8: When two writers of the same register are in flight, the older writer's writeback does not release the register. A reader waits for the writeback of the younger writer.
- R9: A synchronous active-high reset clears every pending flag, so no hold is raised in the cycle after reset.
- R10: For the sequence r1=r2-r3, r2=r1+r3, r3=r1+r2, r1=r2-r2, the second and third instructions each stall two cycles, and the last writeback falls in cycle 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | An instruction occupies the execute stage |
| ex_srcs | input | NUM_SRC*REG_W | Source register numbers of the execute instruction, source 0 in the low bits |
| ex_dst | input | REG_W | Destination of the execute instruction, 0 for none |
| mem_dst | input | REG_W | Destination held in the memory stage, 0 for a bubble or no write |
| wb_dst | input | REG_W | Destination being written back this cycle, 0 for none |
| hold_fetch | output | 1 | Keep the fetch stage contents |
| hold_decode | output | 1 | Keep the decode stage contents |
| hold_execute | output | 1 | Keep the execute stage contents |
| mem_bubble | output | 1 | Load an empty slot into the memory stage |

## Verification
The bench models the pipeline around the block and computes, for each instruction, its execute cycle and writeback cycle. Every hazard is treated as forcing execution one cycle after the producer's writeback. The bench feeds streams that separate the cases:
- a stream with no dependences, which fixes the base timing;
- the four-instruction chain, whose second stall hides a third hazard;
- readers at distance two and three, which place the exact cycle in which a pending flag is released;
- write-after-read and write-after-write streams, which must not stall;
- register 0 and no-destination streams;
- back-to-back writers of one register, which tell an early release from a correct one.

A separate sequence raises a pending flag, resets the block, and confirms the flag is gone.

// File: rtl/raw_pkg.sv
package raw_pkg;

   // Default register-number width: 32 architectural registers.
   localparam int unsigned DEF_REG_W   = 5;
   // Default number of source operands per instruction.
   localparam int unsigned DEF_NUM_SRC = 2;

   // Fan-out of one stall decision to the stage controls.
   typedef struct packed {
      logic hold_fetch;
      logic hold_decode;
      logic hold_execute;
      logic mem_bubble;
   } stall_ctl_t;

   function automatic stall_ctl_t make_stall_ctl(input logic stall);
      stall_ctl_t c;
      c.hold_fetch   = stall;
      c.hold_decode  = stall;
      c.hold_execute = stall;
      c.mem_bubble   = stall;
      return c;
   endfunction

endpackage

// File: rtl/raw_scoreboard.sv
module raw_scoreboard #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned NUM_REGS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                set_en,
   input  logic [REG_W-1:0]    set_idx,
   input  logic                clr_en,
   input  logic [REG_W-1:0]    clr_idx,
   output logic [NUM_REGS-1:0] busy_o
);

   if (NUM_REGS != (1 << REG_W)) begin : g_bad_size
      $error("raw_scoreboard: NUM_REGS must equal 2**REG_W");
   end

   // Register 0 never carries a pending write.
   assign busy_o[0] = 1'b0;

   for (genvar r = 1; r < NUM_REGS; r++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            flag_q <= 1'b0;
         end else if (set_en && (set_idx == REG_W'(r))) begin
            // A new writer wins over a release in the same cycle.
            flag_q <= 1'b1;
         end else if (clr_en && (clr_idx == REG_W'(r))) begin
            flag_q <= 1'b0;
         end
      end
      assign busy_o[r] = flag_q;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (busy_o == '0)); // R9

endmodule

// File: rtl/raw_src_match.sv
module raw_src_match #(
   parameter int unsigned REG_W    = 5,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned NUM_SRC  = 2
) (
   input  logic [NUM_REGS-1:0]      busy_i,
   input  logic [NUM_SRC*REG_W-1:0] srcs_i,
   output logic                     hit_o
);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("raw_src_match: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0] hit_vec;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [REG_W-1:0] idx;
      assign idx        = srcs_i[s*REG_W +: REG_W];
      assign hit_vec[s] = busy_i[idx];
   end

   assign hit_o = |hit_vec;

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
   import raw_pkg::*;
#(
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ex_valid,
   input  logic [NUM_SRC*REG_W-1:0] ex_srcs,
   input  logic [REG_W-1:0]         ex_dst,
   input  logic [REG_W-1:0]         mem_dst,
   input  logic [REG_W-1:0]         wb_dst,
   output logic                     hold_fetch,
   output logic                     hold_decode,
   output logic                     hold_execute,
   output logic                     mem_bubble
);

   localparam int unsigned NUM_REGS = 1 << REG_W;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_width
      $error("raw_interlock: REG_W out of supported range 1..8");
   end

   logic [NUM_REGS-1:0] busy;
   logic                raw_hit;
   logic                stall;
   logic                set_en;
   logic                clr_en;
   stall_ctl_t          ctl;

   raw_src_match #(
      .REG_W    (REG_W),
      .NUM_REGS (NUM_REGS),
      .NUM_SRC  (NUM_SRC)
   ) u_match (
      .busy_i (busy),
      .srcs_i (ex_srcs),
      .hit_o  (raw_hit)
   );

   assign stall = ex_valid & raw_hit;

   // The flag is raised as the writer leaves execute.
   assign set_en = ex_valid & ~stall & (ex_dst != '0);
   // Release on writeback, unless a younger writer of that register sits in memory.
   assign clr_en = (wb_dst != '0) & (mem_dst != wb_dst);

   raw_scoreboard #(
      .REG_W    (REG_W),
      .NUM_REGS (NUM_REGS)
   ) u_board (
      .clk     (clk),
      .rst     (rst),
      .set_en  (set_en),
      .set_idx (ex_dst),
      .clr_en  (clr_en),
      .clr_idx (wb_dst),
      .busy_o  (busy)
   );

   assign ctl          = make_stall_ctl(stall);
   assign hold_fetch   = ctl.hold_fetch;
   assign hold_decode  = ctl.hold_decode;
   assign hold_execute = ctl.hold_execute;
   assign mem_bubble   = ctl.mem_bubble;

   AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ex_valid |-> !hold_execute); // R1
   AST_ZERO_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
      (ex_valid && ex_srcs == '0) |-> !hold_execute); // R7
   AST_WRITER_MARKS: assert property (@(posedge clk) disable iff (rst)
      (ex_valid && !hold_execute && ex_dst != '0) |=> busy[$past(ex_dst)]); // R2
   AST_WB_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (wb_dst != '0 && mem_dst != wb_dst &&
       !(ex_valid && !hold_execute && ex_dst == wb_dst)) |=> !busy[$past(wb_dst)]); // R5
   AST_YOUNGER_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (wb_dst != '0 && mem_dst == wb_dst) |=> busy[$past(wb_dst)]); // R8

endmodule

// File: tb/raw_interlock_bench.sv
`timescale 1ns/1ps
module raw_interlock_bench;

   localparam int REG_W   = 5;
   localparam int NUM_SRC = 2;
   localparam int MAXI    = 8;
   localparam int RUN_CYC = 48;

   logic                     clk = 1'b0;
   logic                     rst = 1'b1;
   logic                     ex_valid;
   logic [NUM_SRC*REG_W-1:0] ex_srcs;
   logic [REG_W-1:0]         ex_dst;
   logic [REG_W-1:0]         mem_dst;
   logic [REG_W-1:0]         wb_dst;
   logic                     hold_fetch;
   logic                     hold_decode;
   logic                     hold_execute;
   logic                     mem_bubble;

   always #2.5 clk = ~clk;

   raw_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_raw_interlock (
      .clk          (clk),
      .rst          (rst),
      .ex_valid     (ex_valid),
      .ex_srcs      (ex_srcs),
      .ex_dst       (ex_dst),
      .mem_dst      (mem_dst),
      .wb_dst       (wb_dst),
      .hold_fetch   (hold_fetch),
      .hold_decode  (hold_decode),
      .hold_execute (hold_execute),
      .mem_bubble   (mem_bubble)
   );

   int p_dst[MAXI];
   int p_a[MAXI];
   int p_b[MAXI];
   int exp_ex[MAXI];
   int exp_wb[MAXI];
   int got_ex[MAXI];
   int got_wb[MAXI];
   int wb_seen[MAXI];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic set_ins(input int k, input int d, input int a, input int b);
      p_dst[k] = d;
      p_a[k]   = a;
      p_b[k]   = b;
   endtask

   task automatic drive(input int ex, input int mem, input int wb);
      if (ex >= 0) begin
         ex_valid = 1'b1;
         ex_srcs  = {REG_W'(p_b[ex]), REG_W'(p_a[ex])};
         ex_dst   = REG_W'(p_dst[ex]);
      end else begin
         ex_valid = 1'b0;
         ex_srcs  = '0;
         ex_dst   = '0;
      end
      mem_dst = (mem >= 0) ? REG_W'(p_dst[mem]) : '0;
      wb_dst  = (wb  >= 0) ? REG_W'(p_dst[wb])  : '0;
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      drive(-1, -1, -1);
      @(posedge clk);
      @(posedge clk);
      #1;
      rst = 1'b0;
   endtask

   // Expected schedule: natural slot, in-order behind the predecessor,
   // and one cycle after the writeback of every earlier producer read.
   task automatic expect_sched(input int n);
      for (int i = 0; i < n; i++) begin
         int e;
         e = i + 3;
         if (i > 0 && exp_ex[i-1] + 1 > e) e = exp_ex[i-1] + 1;
         for (int j = 0; j < i; j++) begin
            if (p_dst[j] != 0 && (p_dst[j] == p_a[i] || p_dst[j] == p_b[i]))
               if (exp_wb[j] + 1 > e) e = exp_wb[j] + 1;
         end
         exp_ex[i] = e;
         exp_wb[i] = e + 2;
      end
   endtask

   task automatic run_seq(input string nm, input string req, input int n);
      int s_if, s_de, s_ex, s_mem, s_wb, nextf, prev_hold;
      int stall_cnt, bubble_cnt, split_cnt, wb_total;
      expect_sched(n);
      for (int i = 0; i < MAXI; i++) begin
         got_ex[i]  = -1;
         got_wb[i]  = -1;
         wb_seen[i] = 0;
      end
      s_if = -1; s_de = -1; s_ex = -1; s_mem = -1; s_wb = -1;
      nextf = 0; prev_hold = 0;
      stall_cnt = 0; bubble_cnt = 0; split_cnt = 0;
      do_reset();
      for (int c = 1; c <= RUN_CYC; c++) begin
         if (prev_hold == 0) begin
            s_wb  = s_mem;
            s_mem = s_ex;
            s_ex  = s_de;
            s_de  = s_if;
            if (nextf < n) begin
               s_if = nextf;
               nextf++;
            end else begin
               s_if = -1;
            end
         end else begin
            s_wb  = s_mem;
            s_mem = -1;
         end
         drive(s_ex, s_mem, s_wb);
         @(negedge clk);
         if (hold_execute) stall_cnt++;
         if (mem_bubble) bubble_cnt++;
         if (hold_fetch != hold_execute || hold_decode != hold_execute) split_cnt++;
         if (s_ex >= 0 && !hold_execute) got_ex[s_ex] = c;
         if (s_wb >= 0) begin
            got_wb[s_wb] = c;
            wb_seen[s_wb]++;
         end
         prev_hold = hold_execute ? 1 : 0;
         @(posedge clk);
         #1;
      end
      drive(-1, -1, -1);
      for (int i = 0; i < n; i++) begin
         chk(req, $sformatf("%s I%0d execute cycle", nm, i + 1), got_ex[i], exp_ex[i]);
         chk(req, $sformatf("%s I%0d writeback cycle", nm, i + 1), got_wb[i], exp_wb[i]);
      end
      chk("R3", $sformatf("%s cycles with unequal holds", nm), split_cnt, 0);
      chk("R3", $sformatf("%s stalled cycles", nm), stall_cnt, exp_ex[n-1] - (n + 2));
      chk("R4", $sformatf("%s bubble cycles", nm), bubble_cnt, stall_cnt);
      wb_total = 0;
      for (int i = 0; i < n; i++) if (wb_seen[i] == 1) wb_total++;
      chk("R4", $sformatf("%s instructions written back once", nm), wb_total, n);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      drive(-1, -1, -1);

      // R9: a flag raised before reset must be gone after it.
      set_ins(0, 9, 0, 0);
      set_ins(1, 0, 9, 9);
      do_reset();
      drive(0, -1, -1);
      @(negedge clk);
      chk("R1", "writer hold", int'(hold_execute), 0);
      @(posedge clk);
      #1;
      drive(1, -1, -1);
      @(negedge clk);
      chk("R2", "reader of pending register held", int'(hold_execute), 1);
      do_reset();
      drive(1, -1, -1);
      @(negedge clk);
      chk("R9", "hold after reset", int'(hold_execute), 0);
      chk("R9", "bubble after reset", int'(mem_bubble), 0);
      @(posedge clk);
      #1;
      drive(-1, -1, -1);

      // R10 / R2: the four-instruction chain.
      set_ins(0, 1, 2, 3);
      set_ins(1, 2, 1, 3);
      set_ins(2, 3, 1, 2);
      set_ins(3, 1, 2, 2);
      run_seq("chain", "R2", 4);
      chk("R10", "chain last writeback cycle", got_wb[3], 12);
      chk("R10", "chain I2 execute cycle", got_ex[1], 6);
      chk("R10", "chain I3 execute cycle", got_ex[2], 9);

      // R1: independent stream.
      set_ins(0, 1, 5, 6);
      set_ins(1, 2, 5, 6);
      set_ins(2, 3, 7, 8);
      set_ins(3, 4, 9, 10);
      run_seq("independent", "R1", 4);
      chk("R1", "independent I4 writeback", got_wb[3], 8);

      // R6: write-after-read and write-after-write.
      set_ins(0, 1, 2, 3);
      set_ins(1, 2, 4, 5);
      set_ins(2, 1, 6, 7);
      set_ins(3, 3, 8, 9);
      run_seq("war_waw", "R6", 4);
      chk("R6", "war_waw I4 execute", got_ex[3], 6);

      // R7: register 0 and no-destination instructions.
      set_ins(0, 0, 4, 5);
      set_ins(1, 6, 0, 0);
      set_ins(2, 8, 0, 0);
      set_ins(3, 0, 0, 0);
      run_seq("zero_reg", "R7", 4);
      chk("R7", "zero_reg I2 execute", got_ex[1], 4);

      // R5: reader two behind stalls one cycle.
      set_ins(0, 1, 2, 3);
      set_ins(1, 4, 5, 6);
      set_ins(2, 7, 1, 1);
      set_ins(3, 8, 0, 0);
      run_seq("distance2", "R5", 4);
      chk("R5", "distance2 I3 execute", got_ex[2], 6);

      // R5: reader three behind does not stall.
      set_ins(0, 1, 2, 3);
      set_ins(1, 4, 5, 6);
      set_ins(2, 7, 8, 9);
      set_ins(3, 10, 1, 0);
      run_seq("distance3", "R5", 4);
      chk("R5", "distance3 I4 execute", got_ex[3], 6);

      // R8: two writers of one register in flight.
      set_ins(0, 5, 1, 2);
      set_ins(1, 5, 3, 4);
      set_ins(2, 6, 5, 0);
      run_seq("waw_inflight", "R8", 3);
      chk("R8", "waw_inflight reader execute", got_ex[2], 7);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule